// File: doc/BRIEF.md
# Justified Double-Buffered DAC Register Front End

This block is the digital side of a 9-bit resistor-ladder DAC that sits in a microcontroller peripheral. Software reaches it over a byte-wide register bus with a write strobe, a 2-bit address, write data and combinational read data. It has a control register and two 8-bit staging bytes. The 9-bit code is split across the two staging bytes in one of two layouts, left or right justified. The code that drives the ladder changes only on the clock edge that completes a write to the high staging byte. Software writes the low byte first and the high byte second, so the ladder never sees a half-updated value.

The block drives the ladder with the active code, the ladder enable and the selection of the positive reference. It also takes over the shared analog/digital pin when the pin output is routed to the ladder. The ideal output is (Vpos − Vneg) × code / 512 + Vneg, with Vneg at ground. A debug output gives the fraction code/512 in Q1.15 form, which means the value is code × 64.

Address map: 0 is control, 1 is the high staging byte, 2 is the low staging byte, and 3 reads as zero and ignores writes.

Top module: `ladder_dac_regs`

## Requirements
- R1: After reset, every register reads 0, and `ladder_code`, `dbg_frac`, `ladder_en`, `ladder_src` and `ladder_to_pin` are all 0.
- R2: In left mode (control bit 4 = 0), a high-byte write latches code[8:1] = written data and code[0] = bit 7 of the low byte.
- R3: In right mode (control bit 4 = 1), a high-byte write latches code[8] = bit 0 of the written data and code[7:0] = the low byte. The other high bits are ignored.
- R4: A write to the low byte or to the control register does not change the active code.
- R5: Both staging bytes read back all 8 bits as written. Control reads back bits 7, 5, 4, 1 and 0 as written, and its other bits read 0.
- R6: While enable (control bit 7) is 0, `ladder_en` is 0 and `ladder_code` and `dbg_frac` are 0. The active register keeps its value and still latches on high-byte writes.
- R7: A change of the justification bit does not re-latch the code. It takes effect only on the next high-byte write.
- R8: While pin output enable (control bit 5) is 1, `ladder_to_pin` is 1, `pin_drv_en` is 0 and `pin_read` is 0. Otherwise `pin_drv_en` follows `gpio_drv_en` and `pin_read` follows `pin_di`.
- R9: `ladder_src` equals control bits 1:0, with 00 = supply, 01 = external reference, 10 = op-amp output and 11 = fixed reference.
- R10: `dbg_frac` equals `ladder_code` × 64, which is code/512 as a Q1.15 fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_di | input | 1 | Raw digital level sensed at the shared pin |
| gpio_drv_en | input | 1 | Digital driver enable requested by the port logic |
| pin_read | output | 1 | Digital pin value returned to software |
| pin_drv_en | output | 1 | Digital driver enable passed to the pad |
| ladder_en | output | 1 | Ladder enable |
| ladder_to_pin | output | 1 | Connects the ladder output to the pin |
| ladder_src | output | 2 | Positive reference select |
| ladder_code | output | 9 | Code applied to the ladder |
| dbg_frac | output | 16 | Ideal output fraction, Q1.15 |

## Verification
The bench targets the bit that crosses bytes in each layout: low bit 7 in left mode and high bit 0 in right mode. If that mapping is wrong, codes such as 0x0FF, 0x100 and 0x1FF come out wrong. It writes the low byte on its own, flips the justification bit, and toggles enable with a high-byte write made while disabled. A design that latches on the low byte, re-latches on a mode change, or clears or freezes the active register while disabled then shows the wrong code. It also drives the pin high while the override is on. A design that leaks the pad level or the driver enable shows a 1 where the requirement expects 0.

// File: rtl/ladder_dac_regs.sv
module ladder_dac_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        pin_di,
  input  logic        gpio_drv_en,
  output logic        pin_read,
  output logic        pin_drv_en,
  output logic        ladder_en,
  output logic        ladder_to_pin,
  output logic [1:0]  ladder_src,
  output logic [8:0]  ladder_code,
  output logic [15:0] dbg_frac
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
  localparam logic [7:0] CTRL_MASK = 8'hB3;

  logic [7:0] ctrl_q, hi_q, lo_q;
  logic [8:0] code_q;

  wire en_b    = ctrl_q[7];
  wire pin_oe  = ctrl_q[5];
  wire right_b = ctrl_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      code_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: ctrl_q <= wdata & CTRL_MASK;
        A_LO:   lo_q   <= wdata;
        A_HI: begin
          hi_q   <= wdata;
          code_q <= right_b ? {wdata[0], lo_q} : {wdata, lo_q[7]};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_HI:    rdata = hi_q;
      A_LO:    rdata = lo_q;
      default: rdata = '0;
    endcase
  end

  assign ladder_en     = en_b;
  assign ladder_to_pin = pin_oe;
  assign ladder_src    = ctrl_q[1:0];
  assign ladder_code   = en_b ? code_q : '0;
  assign dbg_frac      = {1'b0, ladder_code, 6'b0};
  assign pin_drv_en    = gpio_drv_en & ~pin_oe;
  assign pin_read      = pin_di & ~pin_oe;

  AST_LEFT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_HI && !right_b) |=> code_q == {$past(wdata), $past(lo_q[7])}); // R2
  AST_RIGHT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_HI && right_b) |=> code_q == {$past(wdata[0]), $past(lo_q)}); // R3
  AST_NO_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_HI) |=> $stable(code_q)); // R4
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ladder_en |-> (dbg_frac == 16'd0)); // R6
  AST_PIN_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ladder_to_pin |-> (!pin_drv_en && !pin_read)); // R8
endmodule

// File: tb/test_ladder_dac_regs.sv
module test_ladder_dac_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, pin_di = 0, gpio_drv_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic pin_read, pin_drv_en, ladder_en, ladder_to_pin;
  logic [1:0] ladder_src;
  logic [8:0] ladder_code;
  logic [15:0] dbg_frac;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ladder_dac_regs i_ladder_dac_regs (.*);

  // {ctrl, lo, hi, expected code}
  localparam logic [32:0] VEC [8] = '{
    {8'h80, 8'h80, 8'hFF, 9'h1FF},
    {8'h80, 8'h7F, 8'h00, 9'h000},
    {8'h80, 8'h80, 8'h55, 9'h0AB},
    {8'h90, 8'h34, 8'h01, 9'h134},
    {8'h90, 8'hFF, 8'hFE, 9'h0FF},
    {8'h90, 8'h00, 8'h01, 9'h100},
    {8'h81, 8'h00, 8'h80, 9'h100},
    {8'h92, 8'hAA, 8'h03, 9'h1AA}
  };

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string req, input int exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code", ladder_code, 0); chk("R1 frac", dbg_frac, 0);
    chk("R1 en", ladder_en, 0); chk("R1 src", ladder_src, 0); chk("R1 pin", ladder_to_pin, 0);
    rd(0, "R1 ctrl", 0); rd(1, "R1 hi", 0); rd(2, "R1 lo", 0);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      wr(0, VEC[i][32:25]); wr(2, VEC[i][24:17]); wr(1, VEC[i][16:9]);
      chk(VEC[i][28] ? "R3 code" : "R2 code", ladder_code, VEC[i][8:0]);
      chk("R10 frac", dbg_frac, VEC[i][8:0] * 64);
      chk("R9 src", ladder_src, VEC[i][26:25]);
    end
    // last vector: right mode, code 0x1AA, hi=03, lo=AA
    rd(1, "R5 hi", 8'h03); rd(2, "R5 lo", 8'hAA);
    wr(0, 8'hFF); rd(0, "R5 ctrl", 8'hB3);
    wr(3, 8'h5A); rd(3, "R5 unused", 0);
    chk("R4 after ctrl", ladder_code, 9'h1AA);
    wr(2, 8'h11); chk("R4 lo only", ladder_code, 9'h1AA);
    // R8 override active (ctrl=B3)
    pin_di = 1; gpio_drv_en = 1; #1;
    chk("R8 to_pin", ladder_to_pin, 1); chk("R8 drv", pin_drv_en, 0); chk("R8 read", pin_read, 0);
    wr(0, 8'h83); #1;
    chk("R8 drv pass", pin_drv_en, 1); chk("R8 read pass", pin_read, 1);
    // R7 left mode now, code kept
    chk("R7 no relatch", ladder_code, 9'h1AA);
    wr(1, 8'h02); chk("R7 left on hi", ladder_code, 9'h004); // lo=11 -> bit7=0
    // R6 disable
    wr(0, 8'h00);
    chk("R6 code", ladder_code, 0); chk("R6 frac", dbg_frac, 0); chk("R6 en", ladder_en, 0);
    wr(2, 8'h80); wr(1, 8'h40);
    chk("R6 still off", ladder_code, 0);
    wr(0, 8'h80); chk("R6 latched while off", ladder_code, 9'h081);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule